// File: doc/BRIEF.md
# Serial Line Transceiver Power Manager

This block sits next to the analog front end of a multi-channel serial line transceiver and decides when the transmitters and their charge pump may run. An external level detector gives one flag per receiver input. The flag is high while that input carries a voltage that counts as a valid line level. The block synchronizes these flags and applies asymmetric timing to them. It drives a `sig_present_o` status line low only after every input has been quiet for a long qualification window. It drives the line high again shortly after any single input becomes valid.

Two pins set the power policy. The active-low kill pin shuts everything down and overrides all other inputs. The hold-on pin keeps the transmitters running whatever the line activity is. When neither pin is asserted, the block sleeps and wakes automatically from the status line. Leaving power-down passes through a fixed wake-up period with the pump running before the transmitters are enabled. A separate active-low enable controls the receiver output buffers and does nothing else. A two-bit mode output reports which of the four operating modes is in force.

All delays are given in microseconds and converted to clock cycles from a clock-frequency parameter. With the default 1 MHz clock, the quiet window is 30 cycles, the valid window is 1 cycle and the wake-up period is 100 cycles.

Top module: `xcvr_pwr_ctrl`

## Requirements
- R1: While reset is held and right after it, `tx_en_o`, `pump_en_o` and `sig_present_o` are all 0.
- R2: When every level flag is 0, `sig_present_o` falls at the (INV_CYC+2)-th rising clock edge after the flags changed, and not before. This counts two synchronizer stages and INV_CYC qualification cycles.
- R3: When any level flag goes to 1 while `sig_present_o` is 0, `sig_present_o` rises at the (VAL_CYC+2)-th rising edge after the change.
- R4: A valid level seen for even one synchronized cycle during the quiet window restarts that window, so the fall is measured again from the end of the pulse.
- R5: With `kill_n_i` low, `tx_en_o` and `pump_en_o` are 0 from the first rising edge after it goes low, whatever `hold_on_i` and the line activity are.
- R6: With `kill_n_i` high and `hold_on_i` high, the transmitters wake and stay enabled whatever `sig_present_o` does.
- R7: In automatic mode (`kill_n_i`=1, `hold_on_i`=0), `pump_en_o` rises one edge after `sig_present_o` rises. `tx_en_o` rises WAKE_CYC edges later. `tx_en_o`=1 always implies `pump_en_o`=1.
- R8: `rx_oe_o` is all ones when `rx_en_n_i` is 0 and all zeros when it is 1, in every power mode and with no clock delay.
- R9: `sig_present_o` is qualified in every mode, including forced-on and killed.
- R10: In automatic mode, a fall of `sig_present_o` turns off `tx_en_o` and `pump_en_o` at the next edge. This also cuts short a wake-up still in progress.
- R11: `mode_o` encodes 0 = forced on (kill high, hold high), 1 = automatic and awake (kill high, hold low, signal present), 2 = automatic asleep (kill high, hold low, no signal), 3 = killed (kill low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of frequency CLK_HZ |
| rst_n | input | 1 | Synchronous active-low reset |
| lvl_ok_i | input | N_RX | Per-receiver valid-level flags from the level detector (asynchronous) |
| kill_n_i | input | 1 | Active-low forced shutdown, overrides everything |
| hold_on_i | input | 1 | Active-high keep-awake, disables automatic sleep |
| rx_en_n_i | input | 1 | Active-low receiver output enable |
| tx_en_o | output | 1 | Transmitter enable |
| pump_en_o | output | 1 | Charge pump enable |
| rx_oe_o | output | N_RX | Per-receiver output enable (0 = high impedance) |
| sig_present_o | output | 1 | High while some receiver input is qualified valid |
| mode_o | output | 2 | Current operating mode (encoding in R11) |

## Verification
A level flag change reaches `sig_present_o` after two synchronizer edges plus the qualification count, so the bench steps exactly one edge short of that point and confirms the old value, then steps one more edge and confirms the new one. The power outputs lag `sig_present_o` or the kill and hold pins by one registered edge, and `tx_en_o` lags `pump_en_o` by a further WAKE_CYC edges. Each check is placed on both sides of those edges. `rx_oe_o` and `mode_o` are combinational from pins and registered state, so they are sampled one time unit after the stimulus. All sampling happens one time unit after a rising edge, never on it.

// File: rtl/xcvr_pwr_pkg.sv
// Shared types for the transceiver power manager.
// Assumes: a 2-bit mode code consumed outside the block, fixed encoding.
package xcvr_pwr_pkg;

    // Reported operating mode; the values are part of the external contract.
    typedef enum logic [1:0] {
        MODE_FIXED_ON   = 2'd0,
        MODE_AUTO_ON    = 2'd1,
        MODE_AUTO_OFF   = 2'd2,
        MODE_KILLED     = 2'd3
    } xcvr_mode_e;

    // Power sequencer state.
    typedef enum logic [1:0] {
        PS_OFF  = 2'd0,
        PS_WAKE = 2'd1,
        PS_ON   = 2'd2
    } pwr_state_e;

endpackage

// File: rtl/lvl_sync.sv
// Two-stage synchronizer for a vector of independent asynchronous flags.
// Assumes: each bit is a slow level, so per-bit skew between bits is harmless.
module lvl_sync #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic stage1;
        logic stage2;

        // Two flops per bit, cleared to "no valid level" in reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage1 <= 1'b0;
                stage2 <= 1'b0;
            end else begin
                stage1 <= async_i[g];
                stage2 <= stage1;
            end
        end

        assign sync_o[g] = stage2;
    end

endmodule

// File: rtl/sig_qualifier.sv
// Asymmetric qualifier: the output follows "any input valid" only after the
// raw condition has disagreed with it for a full window. The window is
// INV_CYC when falling and VAL_CYC when rising. Any agreeing cycle restarts
// the window.
// Assumes: INV_CYC >= 1 and VAL_CYC >= 1, inputs already synchronized.
module sig_qualifier #(
    parameter int N_RX    = 2,
    parameter int INV_CYC = 30,
    parameter int VAL_CYC = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_RX-1:0] lvl_sync_i,
    output logic            present_o
);

    localparam int MAX_CYC = (INV_CYC > VAL_CYC) ? INV_CYC : VAL_CYC;
    localparam int CW      = $clog2(MAX_CYC + 1);
    localparam logic [CW-1:0] INV_LAST = CW'(INV_CYC - 1);
    localparam logic [CW-1:0] VAL_LAST = CW'(VAL_CYC - 1);

    logic          any_ok;
    logic [CW-1:0] cnt;
    logic [CW-1:0] last;

    assign any_ok = |lvl_sync_i;
    assign last   = present_o ? INV_LAST : VAL_LAST;

    // Count disagreeing cycles; flip the output when the window is used up.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            present_o <= 1'b0;
            cnt       <= '0;
        end else if (present_o == any_ok) begin
            cnt <= '0;
        end else if (cnt == last) begin
            present_o <= ~present_o;
            cnt       <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/pwr_seq.sv
// Power sequencer: settles kill / hold-on / automatic priority, runs the
// pump-first wake-up period and reports the operating mode.
// Assumes: kill_n_i and hold_on_i are synchronous to clk.
module pwr_seq
    import xcvr_pwr_pkg::*;
#(
    parameter int WAKE_CYC = 100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       kill_n_i,
    input  logic       hold_on_i,
    input  logic       present_i,
    output logic       tx_en_o,
    output logic       pump_en_o,
    output xcvr_mode_e mode_o
);

    localparam int WW = $clog2(WAKE_CYC + 1);
    localparam logic [WW-1:0] WAKE_LAST = WW'(WAKE_CYC - 1);

    pwr_state_e    state;
    logic [WW-1:0] wcnt;
    logic          want_on;

    // Kill dominates hold-on, which dominates automatic sleep.
    assign want_on = kill_n_i && (hold_on_i || present_i);

    // State and wake-up timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PS_OFF;
            wcnt  <= '0;
        end else if (!want_on) begin
            state <= PS_OFF;
            wcnt  <= '0;
        end else begin
            case (state)
                PS_OFF: begin
                    state <= PS_WAKE;
                    wcnt  <= '0;
                end
                PS_WAKE: begin
                    if (wcnt == WAKE_LAST) begin
                        state <= PS_ON;
                    end else begin
                        wcnt <= wcnt + 1'b1;
                    end
                end
                default: state <= PS_ON;
            endcase
        end
    end

    assign tx_en_o   = (state == PS_ON);
    assign pump_en_o = (state != PS_OFF);

    // Mode report from the controlling pins and the qualified line status.
    always_comb begin
        if (!kill_n_i)      mode_o = MODE_KILLED;
        else if (hold_on_i) mode_o = MODE_FIXED_ON;
        else if (present_i) mode_o = MODE_AUTO_ON;
        else                mode_o = MODE_AUTO_OFF;
    end

endmodule

// File: rtl/xcvr_pwr_ctrl.sv
// Top of the transceiver power manager. Converts microsecond timing to
// cycles, synchronizes the level flags, qualifies line presence, sequences
// power and drives the receiver output enables.
// Assumes: CLK_HZ is at least 1 kHz; every derived delay is clamped to >= 1.
module xcvr_pwr_ctrl
    import xcvr_pwr_pkg::*;
#(
    parameter int N_RX    = 2,
    parameter int CLK_HZ  = 1_000_000,
    parameter int INV_US  = 30,
    parameter int VAL_US  = 1,
    parameter int WAKE_US = 100
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_RX-1:0] lvl_ok_i,
    input  logic            kill_n_i,
    input  logic            hold_on_i,
    input  logic            rx_en_n_i,
    output logic            tx_en_o,
    output logic            pump_en_o,
    output logic [N_RX-1:0] rx_oe_o,
    output logic            sig_present_o,
    output logic [1:0]      mode_o
);

    localparam int CYC_PER_MS = CLK_HZ / 1000;
    localparam int INV_RAW    = (CYC_PER_MS * INV_US) / 1000;
    localparam int VAL_RAW    = (CYC_PER_MS * VAL_US) / 1000;
    localparam int WAKE_RAW   = (CYC_PER_MS * WAKE_US) / 1000;
    localparam int INV_CYC    = (INV_RAW  < 1) ? 1 : INV_RAW;
    localparam int VAL_CYC    = (VAL_RAW  < 1) ? 1 : VAL_RAW;
    localparam int WAKE_CYC   = (WAKE_RAW < 1) ? 1 : WAKE_RAW;

    logic [N_RX-1:0] lvl_sync;
    xcvr_mode_e      mode;

    lvl_sync #(
        .WIDTH (N_RX)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (lvl_ok_i),
        .sync_o  (lvl_sync)
    );

    sig_qualifier #(
        .N_RX    (N_RX),
        .INV_CYC (INV_CYC),
        .VAL_CYC (VAL_CYC)
    ) u_qual (
        .clk        (clk),
        .rst_n      (rst_n),
        .lvl_sync_i (lvl_sync),
        .present_o  (sig_present_o)
    );

    pwr_seq #(
        .WAKE_CYC (WAKE_CYC)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .kill_n_i  (kill_n_i),
        .hold_on_i (hold_on_i),
        .present_i (sig_present_o),
        .tx_en_o   (tx_en_o),
        .pump_en_o (pump_en_o),
        .mode_o    (mode)
    );

    assign mode_o = mode;

    // Receiver buffers obey only their own enable, never the power state.
    for (genvar g = 0; g < N_RX; g++) begin : g_rx_oe
        assign rx_oe_o[g] = ~rx_en_n_i;
    end

endmodule

// File: rtl/xcvr_pwr_ctrl_chk.sv
// Property checker for the power manager, attached by bind; ports only.
module xcvr_pwr_ctrl_chk #(
    parameter int N_RX = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic [N_RX-1:0] lvl_ok_i,
    input logic            kill_n_i,
    input logic            hold_on_i,
    input logic            rx_en_n_i,
    input logic            tx_en_o,
    input logic            pump_en_o,
    input logic [N_RX-1:0] rx_oe_o,
    input logic            sig_present_o,
    input logic [1:0]      mode_o
);

    // R7
    tx_needs_pump_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_en_o |-> pump_en_o);

    // R5
    kill_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !kill_n_i |=> (!tx_en_o && !pump_en_o));

    // R6
    hold_keeps_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kill_n_i && hold_on_i && tx_en_o) |=> tx_en_o);

    // R10
    auto_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kill_n_i && !hold_on_i && !sig_present_o) |=> (!tx_en_o && !pump_en_o));

    // R7
    wake_via_pump_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_en_o) |-> $past(pump_en_o));

endmodule

bind xcvr_pwr_ctrl xcvr_pwr_ctrl_chk #(.N_RX(N_RX)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .lvl_ok_i      (lvl_ok_i),
    .kill_n_i      (kill_n_i),
    .hold_on_i     (hold_on_i),
    .rx_en_n_i     (rx_en_n_i),
    .tx_en_o       (tx_en_o),
    .pump_en_o     (pump_en_o),
    .rx_oe_o       (rx_oe_o),
    .sig_present_o (sig_present_o),
    .mode_o        (mode_o)
);

// File: tb/xcvr_pwr_ctrl_tb.sv
// Directed bench for the power manager; default parameters (1 MHz clock).
module xcvr_pwr_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int N_RX = 2;
    localparam int INV  = 30;
    localparam int VAL  = 1;
    localparam int WAKE = 100;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [N_RX-1:0] lvl_ok;
    logic            kill_n;
    logic            hold_on;
    logic            rx_en_n;
    logic            tx_en;
    logic            pump_en;
    logic [N_RX-1:0] rx_oe;
    logic            present;
    logic [1:0]      mode;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xcvr_pwr_ctrl #(.N_RX(N_RX)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .lvl_ok_i      (lvl_ok),
        .kill_n_i      (kill_n),
        .hold_on_i     (hold_on),
        .rx_en_n_i     (rx_en_n),
        .tx_en_o       (tx_en),
        .pump_en_o     (pump_en),
        .rx_oe_o       (rx_oe),
        .sig_present_o (present),
        .mode_o        (mode)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0; lvl_ok = '0; kill_n = 1'b1; hold_on = 1'b0; rx_en_n = 1'b0;
        tick(3);
        chk("R1 tx_en in reset", tx_en, 0);
        chk("R1 pump_en in reset", pump_en, 0);
        chk("R1 present in reset", present, 0);
        chk("R11 mode auto asleep", mode, 2);
        chk("R8 rx_oe enabled", rx_oe, 3);
        rst_n = 1'b1;
    endtask

    task automatic t_auto_wake();
        lvl_ok = 2'b01;
        tick(2);
        chk("R3 present not yet", present, 0);
        tick(1);
        chk("R3 present risen", present, 1);
        chk("R11 mode auto awake", mode, 1);
        tick(1);
        chk("R7 pump on after present", pump_en, 1);
        chk("R7 tx still off", tx_en, 0);
        tick(WAKE - 1);
        chk("R7 tx off before wake end", tx_en, 0);
        tick(1);
        chk("R7 tx on after wake", tx_en, 1);
    endtask

    task automatic t_restart_window();
        lvl_ok = 2'b00;
        tick(22);
        chk("R2 present held mid window", present, 1);
        lvl_ok = 2'b10;
        tick(1);
        lvl_ok = 2'b00;
        tick(2 + INV - 1);
        chk("R4 window restarted", present, 1);
        chk("R4 tx still on", tx_en, 1);
        tick(1);
        chk("R2 present fallen", present, 0);
        chk("R11 mode asleep", mode, 2);
        tick(1);
        chk("R10 tx off", tx_en, 0);
        chk("R10 pump off", pump_en, 0);
    endtask

    task automatic t_abort_wake();
        lvl_ok = 2'b01;
        tick(4);
        chk("R7 waking pump", pump_en, 1);
        lvl_ok = 2'b00;
        tick(2 + INV);
        chk("R2 present fell during wake", present, 0);
        chk("R10 pump still on one edge", pump_en, 1);
        tick(1);
        chk("R10 wake aborted pump", pump_en, 0);
        chk("R10 wake aborted tx", tx_en, 0);
    endtask

    task automatic t_hold_on();
        hold_on = 1'b1;
        #1;
        chk("R11 mode forced on", mode, 0);
        tick(1);
        chk("R6 pump on", pump_en, 1);
        tick(WAKE - 1);
        chk("R6 tx not yet", tx_en, 0);
        tick(1);
        chk("R6 tx on without signal", tx_en, 1);
        chk("R9 present low in forced mode", present, 0);
        lvl_ok = 2'b10;
        tick(3);
        chk("R9 present rises in forced mode", present, 1);
        lvl_ok = 2'b00;
        tick(2 + INV + 2);
        chk("R9 present falls in forced mode", present, 0);
        chk("R6 tx stays on", tx_en, 1);
    endtask

    task automatic t_kill();
        lvl_ok = 2'b11;
        tick(3);
        chk("R3 present with both valid", present, 1);
        kill_n = 1'b0;
        #1;
        chk("R11 mode killed", mode, 3);
        tick(1);
        chk("R5 tx off", tx_en, 0);
        chk("R5 pump off", pump_en, 0);
        chk("R9 present kept when killed", present, 1);
        lvl_ok = 2'b00;
        tick(2 + INV);
        chk("R9 present falls when killed", present, 0);
        hold_on = 1'b0;
        kill_n  = 1'b1;
        #1;
        chk("R11 mode back to asleep", mode, 2);
        tick(5);
        chk("R10 stays asleep", pump_en, 0);
    endtask

    task automatic t_rx_enable();
        rx_en_n = 1'b1;
        #1;
        chk("R8 rx_oe off", rx_oe, 0);
        hold_on = 1'b1;
        tick(WAKE + 2);
        chk("R6 tx on again", tx_en, 1);
        chk("R8 rx_oe unaffected by power", rx_oe, 0);
        kill_n = 1'b0;
        rx_en_n = 1'b0;
        #1;
        chk("R8 rx_oe on while killed", rx_oe, 3);
        tick(1);
        chk("R5 killed over hold", tx_en, 0);
    endtask

    initial begin
        t_reset();
        t_auto_wake();
        t_restart_window();
        t_abort_wake();
        t_hold_on();
        t_kill();
        t_rx_enable();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule